// File: doc/BRIEF.md
# Locked configuration-register port with banked logical devices

This block is the host-side front end for the configuration space of a legacy multi-function I/O device. The host sees two byte ports next to each other in I/O space. The lower one is an index port and the upper one is a data port. After reset the block is locked. While it is locked, only a fixed four-byte key written to the index port has any effect. Once the key has been matched, the host writes a register number to the index port and then reads or writes that register through the data port.

Indices below 0x30 are global and are handled inside the block: a logical-device selector, a 16-bit identification value and a revision nibble. Indices from 0x30 upward are banked. They go out on a simple downstream register bus, tagged with the logical device that is currently selected, so each logical device keeps its own enable register (0x30) and base-address pair (0x60 high byte, 0x61 low byte) behind the bus. To lock the port again, the host writes 0x02 to the index port and then 0x02 to the data port.

The lock state machine has five states. LOCKED waits for the first key byte. KEY1, KEY2 and KEY3 each hold the progress made so far. OPEN grants access. The transitions are:
- **advance**: the expected key byte arrives, so the machine moves one step forward.
- **restart**: a wrong byte arrives, so the machine goes back to LOCKED.
- **re-arm**: the wrong byte is the first key byte, so the machine goes to KEY1.
- **unlock**: in KEY3, the final key byte moves the machine to OPEN.
- **exit**: in OPEN, the exit command moves the machine back to LOCKED.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is locked, `cfg_open` is 0, `dev_ldn` is 0, and a data-port read returns 0xFF.
- R2: The index port is at host address BASE (default 0x002E) and the data port is at BASE+1 (0x002F). A write to any other address changes nothing, including key matching. A read from any other address returns 0xFF.
- R3: Write 0x87, 0x01, 0x55, 0x55 to the index port in that order. `cfg_open` then goes to 1 after the clock edge that takes the fourth byte.
- R4: A wrong index-port byte during matching restarts the key. If that byte is 0x87, it counts as the first key byte.
- R5: While locked, the following all hold:
  - Reads of the index port and the data port return 0xFF.
  - Data-port writes have no effect and raise no `dev_wr`.
  - Data-port accesses do not disturb key matching.
- R6: Writing 0x02 to the index port and then 0x02 to the data port locks the port after that data write's clock edge. A data value other than 0x02 at index 0x02 keeps the port open. The index register reads 0x00 after every unlock.
- R7: While open, an index-port read returns the last index written.
- R8: Index 0x07 is the logical-device selector and reads back what was written. It drives `dev_ldn`, changes only on a data write to it while open, and keeps its value while the port is locked.
- R9: Index 0x20 reads the high byte of CHIP_ID and index 0x21 reads the low byte. Index 0x22 reads CHIP_REV in bits 3:0 with bits 7:4 at 0. Writes to these three indices are ignored.
- R10: For index 0x30 or higher, a data write pulses `dev_wr` and a data read pulses `dev_rd`, in the same cycle as the access. `dev_idx`, `dev_wdata` and `dev_ldn` are valid during the pulse, and the read returns `dev_rdata`. Each logical device number addresses a separate bank.
- R11: Any other global index below 0x30 reads 0x00, ignores writes and raises no downstream strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | ADDR_W | Host I/O address of the access |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid in the cycle of `host_rd` |
| cfg_open | output | 1 | 1 while configuration access is unlocked |
| dev_ldn | output | LDN_W | Selected logical device number |
| dev_idx | output | 8 | Register index for the downstream access |
| dev_wr | output | 1 | Downstream write strobe |
| dev_rd | output | 1 | Downstream read strobe |
| dev_wdata | output | 8 | Downstream write byte |
| dev_rdata | input | 8 | Downstream read byte from the selected device |

## Verification
The unlock detector is driven with four kinds of stimulus:
- **Clean key**: shows that the machine advances through every state.
- **Key broken by an unrelated byte**: shows the restart path.
- **Key broken by a second 0x87**: separates restart from re-arm.
- **Key with data-port traffic between its bytes**: shows that only index writes are matched.

Further tests cover the following:
- **Correct key at the wrong host address**: confirms the address decode.
- **Index 0x02 with a value other than 0x02**: separates the real exit from a near miss.
- **Banked accesses under two device numbers**: show that the selector really picks separate banks.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    // Lock/unlock state machine states
    typedef enum logic [2:0] {
        KS_LOCKED,
        KS_KEY1,
        KS_KEY2,
        KS_KEY3,
        KS_OPEN
    } key_state_e;

    // Decoded host access strobes
    typedef struct packed {
        logic idx_wr;
        logic idx_rd;
        logic dat_wr;
        logic dat_rd;
    } host_acc_t;

    // Unlock key, matched in order on the index port
    localparam logic [7:0] KEY_B0 = 8'h87;
    localparam logic [7:0] KEY_B1 = 8'h01;
    localparam logic [7:0] KEY_B2 = 8'h55;
    localparam logic [7:0] KEY_B3 = 8'h55;

    // Exit command: this index, then this value on the data port
    localparam logic [7:0] EXIT_IDX = 8'h02;
    localparam logic [7:0] EXIT_VAL = 8'h02;

    // Global register indices
    localparam logic [7:0] IDX_LDN   = 8'h07;
    localparam logic [7:0] IDX_ID_HI = 8'h20;
    localparam logic [7:0] IDX_ID_LO = 8'h21;
    localparam logic [7:0] IDX_REV   = 8'h22;

    // First index that is banked per logical device
    localparam logic [7:0] IDX_BANK_LO = 8'h30;

    // Value returned when nothing is decoded or the port is locked
    localparam logic [7:0] IDLE_READ = 8'hFF;

endpackage

// File: rtl/sio_addr_decode.sv
module sio_addr_decode
    import sio_cfg_pkg::*;
#(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'h002E
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output host_acc_t         acc
);

    localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(BASE + 1);

    logic hit_idx;
    logic hit_dat;

    always_comb begin
        hit_idx    = (addr == BASE);
        hit_dat    = (addr == DATA_ADDR);
        acc.idx_wr = hit_idx & wr;
        acc.idx_rd = hit_idx & rd;
        acc.dat_wr = hit_dat & wr;
        acc.dat_rd = hit_dat & rd;
    end

endmodule

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  host_acc_t  acc,
    input  logic [7:0] wdata,
    input  logic [7:0] cur_index,
    output logic       cfg_open
);

    key_state_e state;
    key_state_e state_nxt;

    // A wrong key byte re-arms on the first key byte, otherwise it restarts
    function automatic key_state_e miss_target(input logic [7:0] b);
        return (b == KEY_B0) ? KS_KEY1 : KS_LOCKED;
    endfunction

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= KS_LOCKED;
        else        state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            KS_LOCKED: begin
                if (acc.idx_wr && wdata == KEY_B0) state_nxt = KS_KEY1;
            end
            KS_KEY1: begin
                if (acc.idx_wr)
                    state_nxt = (wdata == KEY_B1) ? KS_KEY2 : miss_target(wdata);
            end
            KS_KEY2: begin
                if (acc.idx_wr)
                    state_nxt = (wdata == KEY_B2) ? KS_KEY3 : miss_target(wdata);
            end
            KS_KEY3: begin
                if (acc.idx_wr)
                    state_nxt = (wdata == KEY_B3) ? KS_OPEN : miss_target(wdata);
            end
            KS_OPEN: begin
                if (acc.dat_wr && cur_index == EXIT_IDX && wdata == EXIT_VAL)
                    state_nxt = KS_LOCKED;
            end
            default: state_nxt = KS_LOCKED;
        endcase
    end

    // Outputs
    always_comb begin
        cfg_open = (state == KS_OPEN);
    end

endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
    import sio_cfg_pkg::*;
#(
    parameter int          LDN_W    = 8,
    parameter logic [15:0] CHIP_ID  = 16'hC0DE,
    parameter logic [3:0]  CHIP_REV = 4'h3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  host_acc_t        acc,
    input  logic [7:0]       wdata,
    input  logic             cfg_open,
    input  logic [7:0]       dev_rdata,
    output logic [7:0]       index_q,
    output logic [LDN_W-1:0] ldn_q,
    output logic [7:0]       host_rdata,
    output logic             dev_wr,
    output logic             dev_rd,
    output logic [7:0]       dev_idx,
    output logic [7:0]       dev_wdata
);

    logic       banked;
    logic [7:0] ldn_byte;

    // Index register: cleared whenever the port is locked
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_open) index_q <= 8'h00;
        else if (acc.idx_wr)     index_q <= wdata;
    end

    // Logical device selector: kept across lock and unlock
    always_ff @(posedge clk) begin
        if (!rst_n)
            ldn_q <= '0;
        else if (cfg_open && acc.dat_wr && index_q == IDX_LDN)
            ldn_q <= wdata[LDN_W-1:0];
    end

    // Downstream register bus
    always_comb begin
        banked    = (index_q >= IDX_BANK_LO);
        dev_wr    = cfg_open & acc.dat_wr & banked;
        dev_rd    = cfg_open & acc.dat_rd & banked;
        dev_idx   = index_q;
        dev_wdata = wdata;
    end

    // Host read path
    always_comb begin
        ldn_byte              = 8'h00;
        ldn_byte[LDN_W-1:0]   = ldn_q;
        host_rdata            = IDLE_READ;
        if (cfg_open && acc.idx_rd) begin
            host_rdata = index_q;
        end else if (cfg_open && acc.dat_rd) begin
            if (banked) begin
                host_rdata = dev_rdata;
            end else begin
                case (index_q)
                    IDX_LDN:   host_rdata = ldn_byte;
                    IDX_ID_HI: host_rdata = CHIP_ID[15:8];
                    IDX_ID_LO: host_rdata = CHIP_ID[7:0];
                    IDX_REV:   host_rdata = {4'h0, CHIP_REV};
                    default:   host_rdata = 8'h00;
                endcase
            end
        end
    end

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] BASE     = 16'h002E,
    parameter int                LDN_W    = 8,
    parameter logic [15:0]       CHIP_ID  = 16'hC0DE,
    parameter logic [3:0]        CHIP_REV = 4'h3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              cfg_open,
    output logic [LDN_W-1:0]  dev_ldn,
    output logic [7:0]        dev_idx,
    output logic              dev_wr,
    output logic              dev_rd,
    output logic [7:0]        dev_wdata,
    input  logic [7:0]        dev_rdata
);

    host_acc_t  acc;
    logic [7:0] index_q;

    sio_addr_decode #(
        .ADDR_W (ADDR_W),
        .BASE   (BASE)
    ) u_dec (
        .addr (host_addr),
        .wr   (host_wr),
        .rd   (host_rd),
        .acc  (acc)
    );

    sio_key_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .wdata     (host_wdata),
        .cur_index (index_q),
        .cfg_open  (cfg_open)
    );

    sio_cfg_regs #(
        .LDN_W    (LDN_W),
        .CHIP_ID  (CHIP_ID),
        .CHIP_REV (CHIP_REV)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (acc),
        .wdata      (host_wdata),
        .cfg_open   (cfg_open),
        .dev_rdata  (dev_rdata),
        .index_q    (index_q),
        .ldn_q      (dev_ldn),
        .host_rdata (host_rdata),
        .dev_wr     (dev_wr),
        .dev_rd     (dev_rd),
        .dev_idx    (dev_idx),
        .dev_wdata  (dev_wdata)
    );

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'h002E,
    parameter int                LDN_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_wr,
    input logic              host_rd,
    input logic [7:0]        host_wdata,
    input logic [7:0]        host_rdata,
    input logic              cfg_open,
    input logic [LDN_W-1:0]  dev_ldn,
    input logic [7:0]        dev_idx,
    input logic              dev_wr,
    input logic              dev_rd
);

    localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(BASE + 1);

    // R3
    unlock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(host_wr && host_addr == BASE && host_wdata == 8'h55));

    // R6
    exit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_open) |-> $past(host_wr && host_addr == DATA_ADDR && host_wdata == 8'h02));

    // R5
    locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && host_rd && host_addr == DATA_ADDR) |-> (host_rdata == 8'hFF));

    // R10
    bank_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_wr || dev_rd) |-> (cfg_open && dev_idx >= 8'h30));

    // R8
    ldn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(host_wr) |-> $stable(dev_ldn));

    // R2
    foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr != BASE && host_addr != DATA_ADDR) |=> $stable(cfg_open));

endmodule

bind sio_cfg_port sio_cfg_port_chk #(
    .ADDR_W (ADDR_W),
    .BASE   (BASE),
    .LDN_W  (LDN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .cfg_open   (cfg_open),
    .dev_ldn    (dev_ldn),
    .dev_idx    (dev_idx),
    .dev_wr     (dev_wr),
    .dev_rd     (dev_rd)
);

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb;

    localparam int          CLK_P  = 10;
    localparam logic [15:0] IA     = 16'h002E;
    localparam logic [15:0] DA     = 16'h002F;
    localparam logic [15:0] CID    = 16'hC0DE;
    localparam logic [3:0]  CREV   = 4'h3;

    typedef struct packed {
        logic        rd;
        logic [15:0] addr;
        logic [7:0]  data;
        logic [7:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 37;
    localparam vec_t VEC [NV] = '{
        // R3 unlock key
        '{1'b0, IA, 8'h87, 8'h00, 4'd3},
        '{1'b0, IA, 8'h01, 8'h00, 4'd3},
        '{1'b0, IA, 8'h55, 8'h00, 4'd3},
        '{1'b0, IA, 8'h55, 8'h00, 4'd3},
        // R6 index cleared at unlock
        '{1'b1, IA, 8'h00, 8'h00, 4'd6},
        // R9 identification and revision
        '{1'b0, IA, 8'h20, 8'h00, 4'd9},
        '{1'b1, DA, 8'h00, CID[15:8], 4'd9},
        '{1'b0, IA, 8'h21, 8'h00, 4'd9},
        '{1'b1, DA, 8'h00, CID[7:0], 4'd9},
        '{1'b0, IA, 8'h22, 8'h00, 4'd9},
        '{1'b1, DA, 8'h00, {4'h0, CREV}, 4'd9},
        '{1'b0, DA, 8'hFF, 8'h00, 4'd9},
        '{1'b1, DA, 8'h00, {4'h0, CREV}, 4'd9},
        // R8 selector, R7 index readback
        '{1'b0, IA, 8'h07, 8'h00, 4'd8},
        '{1'b0, DA, 8'h01, 8'h00, 4'd8},
        '{1'b1, DA, 8'h00, 8'h01, 4'd8},
        '{1'b1, IA, 8'h00, 8'h07, 4'd7},
        // R10 banked registers of device 1
        '{1'b0, IA, 8'h30, 8'h00, 4'd10},
        '{1'b0, DA, 8'h01, 8'h00, 4'd10},
        '{1'b1, DA, 8'h00, 8'h01, 4'd10},
        '{1'b0, IA, 8'h60, 8'h00, 4'd10},
        '{1'b0, DA, 8'h02, 8'h00, 4'd10},
        '{1'b0, IA, 8'h61, 8'h00, 4'd10},
        '{1'b0, DA, 8'h9A, 8'h00, 4'd10},
        '{1'b1, DA, 8'h00, 8'h9A, 4'd10},
        '{1'b0, IA, 8'h60, 8'h00, 4'd10},
        '{1'b1, DA, 8'h00, 8'h02, 4'd10},
        // R10 device 2 is a separate bank
        '{1'b0, IA, 8'h07, 8'h00, 4'd10},
        '{1'b0, DA, 8'h02, 8'h00, 4'd10},
        '{1'b0, IA, 8'h30, 8'h00, 4'd10},
        '{1'b1, DA, 8'h00, 8'h00, 4'd10},
        // R11 unused global index
        '{1'b0, IA, 8'h25, 8'h00, 4'd11},
        '{1'b0, DA, 8'h77, 8'h00, 4'd11},
        '{1'b1, DA, 8'h00, 8'h00, 4'd11},
        // R6 near-miss exit keeps the port open
        '{1'b0, IA, 8'h02, 8'h00, 4'd6},
        '{1'b0, DA, 8'h05, 8'h00, 4'd6},
        '{1'b1, IA, 8'h00, 8'h02, 4'd6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] h_addr = 16'h0000;
    logic        h_wr = 1'b0;
    logic        h_rd = 1'b0;
    logic [7:0]  h_wdata = 8'h00;
    logic [7:0]  h_rdata;
    logic        cfg_open;
    logic [7:0]  dev_ldn;
    logic [7:0]  dev_idx;
    logic        dev_wr;
    logic        dev_rd;
    logic [7:0]  dev_wdata;
    logic [7:0]  dev_rdata;

    logic [7:0] dev_mem [0:3][0:255];
    int         n_devwr;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    sio_cfg_port #(
        .ADDR_W   (16),
        .BASE     (IA),
        .LDN_W    (8),
        .CHIP_ID  (CID),
        .CHIP_REV (CREV)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (h_addr),
        .host_wr    (h_wr),
        .host_rd    (h_rd),
        .host_wdata (h_wdata),
        .host_rdata (h_rdata),
        .cfg_open   (cfg_open),
        .dev_ldn    (dev_ldn),
        .dev_idx    (dev_idx),
        .dev_wr     (dev_wr),
        .dev_rd     (dev_rd),
        .dev_wdata  (dev_wdata),
        .dev_rdata  (dev_rdata)
    );

    // Model of the logical devices behind the downstream bus
    assign dev_rdata = dev_mem[dev_ldn[1:0]][dev_idx];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < 4; d++)
                for (int i = 0; i < 256; i++)
                    dev_mem[d][i] <= 8'h00;
            n_devwr <= 0;
        end else if (dev_wr) begin
            dev_mem[dev_ldn[1:0]][dev_idx] <= dev_wdata;
            n_devwr <= n_devwr + 1;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        h_addr  = a;
        h_wdata = d;
        h_wr    = 1'b1;
        @(negedge clk);
        h_wr    = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        h_addr = a;
        h_rd   = 1'b1;
        #1 d = h_rdata;
        @(posedge clk);
        #1 h_rd = 1'b0;
    endtask

    task automatic key(input logic [15:0] a);
        wr(a, 8'h87); wr(a, 8'h01); wr(a, 8'h55); wr(a, 8'h55);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check("R1 open", {7'b0, cfg_open}, 8'h00);
        check("R1 ldn", dev_ldn, 8'h00);
        rd(DA, r);
        check("R1 data read", r, 8'hFF);

        // Vector table
        for (int k = 0; k < NV; k++) begin
            if (VEC[k].rd) begin
                rd(VEC[k].addr, r);
                check($sformatf("R%0d vec %0d", VEC[k].req, k), r, VEC[k].exp);
            end else begin
                wr(VEC[k].addr, VEC[k].data);
            end
        end
        check("R3 open after key", {7'b0, cfg_open}, 8'h01);
        // R10 exactly three banked writes, none from R11 index
        check("R10 dev_wr count", 8'(n_devwr), 8'd3);

        // R6 exit command
        wr(IA, 8'h02);
        wr(DA, 8'h02);
        check("R6 locked after exit", {7'b0, cfg_open}, 8'h00);

        // R5 locked behaviour
        rd(IA, r);
        check("R5 index read locked", r, 8'hFF);
        rd(DA, r);
        check("R5 data read locked", r, 8'hFF);
        wr(DA, 8'h07);
        check("R5 no dev_wr locked", 8'(n_devwr), 8'd3);
        check("R8 ldn kept while locked", dev_ldn, 8'h02);

        // R4 broken key, then re-arm on 0x87
        wr(IA, 8'h87); wr(IA, 8'h01); wr(IA, 8'h55); wr(IA, 8'h00); wr(IA, 8'h55);
        check("R4 broken key stays locked", {7'b0, cfg_open}, 8'h00);
        wr(IA, 8'h87); wr(IA, 8'h01); wr(IA, 8'h87); wr(IA, 8'h01);
        wr(IA, 8'h55); wr(IA, 8'h55);
        check("R4 re-armed key opens", {7'b0, cfg_open}, 8'h01);

        // R6 index cleared after unlock, R8 selector retained
        rd(IA, r);
        check("R6 index zero after unlock", r, 8'h00);
        wr(IA, 8'h07);
        rd(DA, r);
        check("R8 selector retained", r, 8'h02);

        // R2 foreign address has no effect
        wr(16'h0080, 8'h22);
        rd(IA, r);
        check("R2 index untouched", r, 8'h07);
        rd(16'h002D, r);
        check("R2 foreign read", r, 8'hFF);

        // R5 data-port traffic between key bytes does not disturb matching
        wr(IA, 8'h02);
        wr(DA, 8'h02);
        wr(IA, 8'h87);
        wr(IA, 8'h01);
        wr(DA, 8'h99);
        rd(DA, r);
        wr(IA, 8'h55);
        wr(IA, 8'h55);
        check("R5 key with data traffic opens", {7'b0, cfg_open}, 8'h01);

        // R2 key at the wrong address does not unlock
        wr(IA, 8'h02);
        wr(DA, 8'h02);
        key(16'h004E);
        check("R2 key at foreign address", {7'b0, cfg_open}, 8'h00);
        key(IA);
        check("R3 key opens again", {7'b0, cfg_open}, 8'h01);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule